// File: doc/BRIEF.md
# Reset Boot Source Selector

This block decides, once per reset, where the processor starts running. After reset is released, it reads three inputs: an active-low external force-boot pin, passed through a synchronizer; an active-low jump fuse bit; and an 8-bit software boot vector. From them it produces the reset program counter, the initial boot-region mapping flag and a flash-control marker byte. It then dispatches to one of three targets: the user application at 0000h, a user bootloader at a page chosen by the vector, or the internal bootloader at F000h.

The block also holds a small auxiliary control register. Software uses it to map or unmap the boot region later, and it carries a general-purpose flag and a data-pointer select bit. All pins are plain control and status signals. There is no streamed data, so no valid/ready handshake is involved. `boot_ready` marks the cycle from which the decision outputs are final.

Top module: `boot_source_sel`

## Requirements
- R1: If the synchronized force-boot pin is low at the decision point, the block sets `boot_map_en`=1, `reset_pc`=F000h and `flash_marker`=00h, and `dispatch_tgt` selects the internal bootloader (code 2) with `dispatch_addr`=F000h. This holds whatever the fuse and vector are.
- R2: Otherwise, if the jump fuse is programmed (`fuse_jump_n`=0), the block sets `boot_map_en`=1, `reset_pc`=F000h and `flash_marker`=F0h.
- R3: Otherwise the block sets `boot_map_en`=0, `reset_pc`=0000h and `flash_marker`=F0h, and `dispatch_tgt` is the user application (code 0) with `dispatch_addr`=0000h.
- R4: While reset is held, and until the decision is taken, the outputs are `boot_ready`=0, `reset_pc`=0000h, `flash_marker`=F0h, `boot_map_en`=0 and `reg_rd_data`=00h. With SYNC_STAGES=2, the decision is taken on the third rising clock edge after reset is released, and `boot_ready` is 1 from that edge on. The pin value used is the one present at the first edge.
- R5: When the boot region was mapped at reset and the marker is F0h, the dispatch depends on the vector. A vector below F0h selects the user bootloader (code 1) at address {vector, 00h}. A vector of F0h or above selects the internal bootloader (code 2) at F000h.
- R6: The auxiliary register reads as follows. Bit 5 is the boot-map enable and drives `boot_map_en`. Bit 3 is a general flag and bit 0 is the data-pointer select; both are writable. Bit 2 and all other bits always read 0, and writes to them have no effect. After the decision, bit 5 holds the R1–R3 mapping value and the other bits read 0.
- R7: A register write presented while `boot_ready` is 0 is ignored.
- R8: Once `boot_ready` is 1, later changes of the pin, the fuse or the vector have no effect on `reset_pc`, `flash_marker`, `dispatch_tgt` or `dispatch_addr`. Rewriting bit 5 changes only `boot_map_en`, not the dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isp_force_n | input | 1 | External force-boot pin, active low, asynchronous |
| fuse_jump_n | input | 1 | Jump fuse, 0 = programmed |
| sw_boot_vec | input | 8 | Software boot vector byte |
| reg_wr_en | input | 1 | Auxiliary register write strobe |
| reg_wr_data | input | 8 | Auxiliary register write data |
| reg_rd_data | output | 8 | Auxiliary register read value |
| boot_map_en | output | 1 | Boot region F000h–FFFFh mapped into code space |
| boot_ready | output | 1 | Decision outputs are final |
| reset_pc | output | 16 | Reset program counter |
| flash_marker | output | 8 | Flash-control marker value |
| dispatch_tgt | output | 2 | 0 user application, 1 user bootloader, 2 internal bootloader |
| dispatch_addr | output | 16 | Start address of the dispatch target |

## Verification
The hardest case to reach from the ports is a pin value that changes while it is still inside the synchronizer. The decision must use the value seen at the first edge after release, not the value present at the decision edge. The stimulus releases reset with the pin at one level and flips it one cycle later. It then changes the pin, fuse and vector after `boot_ready` rises, and attempts register writes during the synchronizer wait. The per-cycle model shows whether any of these leak into the latched outputs.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  typedef enum logic [1:0] {
    TGT_USER_APP  = 2'd0,
    TGT_USER_BOOT = 2'd1,
    TGT_INTERNAL  = 2'd2
  } boot_tgt_e;

  typedef struct packed {
    logic        map_en;
    logic [15:0] pc;
    logic [7:0]  marker;
  } stage1_t;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/boot_stage1.sv
module boot_stage1
  import boot_sel_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          PAGE_W    = 8,
  parameter logic [7:0]  BOOT_PAGE = 8'hF0,
  parameter logic [7:0]  MARK_HW   = 8'h00,
  parameter logic [7:0]  MARK_STD  = 8'hF0
) (
  input  logic    force_n_i,
  input  logic    fuse_n_i,
  output stage1_t res_o
);
  localparam int VEC_W = ADDR_W - PAGE_W;
  localparam logic [ADDR_W-1:0] BOOT_PC = {BOOT_PAGE[VEC_W-1:0], {PAGE_W{1'b0}}};

  always_comb begin
    if (!force_n_i) begin
      res_o.map_en = 1'b1;
      res_o.pc     = BOOT_PC;
      res_o.marker = MARK_HW;
    end else if (!fuse_n_i) begin
      res_o.map_en = 1'b1;
      res_o.pc     = BOOT_PC;
      res_o.marker = MARK_STD;
    end else begin
      res_o.map_en = 1'b0;
      res_o.pc     = '0;
      res_o.marker = MARK_STD;
    end
  end
endmodule

// File: rtl/boot_dispatch.sv
module boot_dispatch
  import boot_sel_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          PAGE_W    = 8,
  parameter logic [7:0]  BOOT_PAGE = 8'hF0,
  parameter logic [7:0]  MARK_HW   = 8'h00
) (
  input  logic                       init_en_i,
  input  logic [7:0]                 marker_i,
  input  logic [ADDR_W-PAGE_W-1:0]   vec_i,
  output boot_tgt_e                  tgt_o,
  output logic [ADDR_W-1:0]          addr_o
);
  localparam int VEC_W = ADDR_W - PAGE_W;
  localparam logic [VEC_W-1:0] VEC_LIMIT = BOOT_PAGE[VEC_W-1:0];

  always_comb begin
    if (!init_en_i) begin
      tgt_o  = TGT_USER_APP;
      addr_o = '0;
    end else if (marker_i == MARK_HW) begin
      tgt_o  = TGT_INTERNAL;
      addr_o = {VEC_LIMIT, {PAGE_W{1'b0}}};
    end else if (vec_i < VEC_LIMIT) begin
      tgt_o  = TGT_USER_BOOT;
      addr_o = {vec_i, {PAGE_W{1'b0}}};
    end else begin
      tgt_o  = TGT_INTERNAL;
      addr_o = {VEC_LIMIT, {PAGE_W{1'b0}}};
    end
  end
endmodule

// File: rtl/aux_ctrl_reg.sv
module aux_ctrl_reg #(
  parameter int DATA_W   = 8,
  parameter int MAP_BIT  = 5,
  parameter int FLAG_BIT = 3,
  parameter int DPS_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              load_map_i,
  input  logic              wr_allow_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              map_en_o
);
  localparam logic [DATA_W-1:0] WR_MASK =
    (DATA_W'(1) << MAP_BIT) | (DATA_W'(1) << FLAG_BIT) | (DATA_W'(1) << DPS_BIT);

  logic [DATA_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (load_i) begin
      reg_q          <= '0;
      reg_q[MAP_BIT] <= load_map_i;
    end else if (wr_allow_i && wr_en_i) begin
      reg_q <= wr_data_i & WR_MASK;
    end
  end

  assign rd_data_o = reg_q;
  assign map_en_o  = reg_q[MAP_BIT];

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ~WR_MASK) == '0); // R6
  AST_EARLY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_allow_i && !load_i) |=> $stable(rd_data_o)); // R7
endmodule

// File: rtl/boot_source_sel.sv
module boot_source_sel
  import boot_sel_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 16,
  parameter int          PAGE_W      = 8,
  parameter logic [7:0]  BOOT_PAGE   = 8'hF0,
  parameter logic [7:0]  MARK_HW     = 8'h00,
  parameter logic [7:0]  MARK_STD    = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isp_force_n,
  input  logic              fuse_jump_n,
  input  logic [7:0]        sw_boot_vec,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wr_data,
  output logic [7:0]        reg_rd_data,
  output logic              boot_map_en,
  output logic              boot_ready,
  output logic [ADDR_W-1:0] reset_pc,
  output logic [7:0]        flash_marker,
  output logic [1:0]        dispatch_tgt,
  output logic [ADDR_W-1:0] dispatch_addr
);
  localparam int VEC_W = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(SYNC_STAGES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_STAGES);
  localparam logic [ADDR_W-1:0] BOOT_PC = {BOOT_PAGE[VEC_W-1:0], {PAGE_W{1'b0}}};

  logic             force_sync;
  stage1_t          s1;
  logic [CNT_W-1:0] wait_cnt_q;
  logic             ready_q;
  logic             take;
  logic             init_en_q;
  logic [15:0]      pc_q;
  logic [7:0]       marker_q;
  logic [VEC_W-1:0] vec_q;
  boot_tgt_e        tgt;

  isp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (isp_force_n),
    .sync_o  (force_sync)
  );

  boot_stage1 #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BOOT_PAGE(BOOT_PAGE),
    .MARK_HW(MARK_HW), .MARK_STD(MARK_STD)
  ) u_stage1 (
    .force_n_i (force_sync),
    .fuse_n_i  (fuse_jump_n),
    .res_o     (s1)
  );

  assign take = !ready_q && (wait_cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt_q <= '0;
      ready_q    <= 1'b0;
      init_en_q  <= 1'b0;
      pc_q       <= '0;
      marker_q   <= MARK_STD;
      vec_q      <= '1;
    end else if (take) begin
      ready_q   <= 1'b1;
      init_en_q <= s1.map_en;
      pc_q      <= s1.pc;
      marker_q  <= s1.marker;
      vec_q     <= sw_boot_vec[VEC_W-1:0];
    end else if (!ready_q) begin
      wait_cnt_q <= wait_cnt_q + 1'b1;
    end
  end

  boot_dispatch #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BOOT_PAGE(BOOT_PAGE), .MARK_HW(MARK_HW)
  ) u_dispatch (
    .init_en_i (init_en_q),
    .marker_i  (marker_q),
    .vec_i     (vec_q),
    .tgt_o     (tgt),
    .addr_o    (dispatch_addr)
  );

  aux_ctrl_reg #(.DATA_W(8)) u_aux (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (take),
    .load_map_i (s1.map_en),
    .wr_allow_i (ready_q),
    .wr_en_i    (reg_wr_en),
    .wr_data_i  (reg_wr_data),
    .rd_data_o  (reg_rd_data),
    .map_en_o   (boot_map_en)
  );

  assign boot_ready   = ready_q;
  assign reset_pc     = pc_q[ADDR_W-1:0];
  assign flash_marker = marker_q;
  assign dispatch_tgt = tgt;

  AST_FORCED_TO_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_ready && flash_marker == MARK_HW) |->
      (dispatch_tgt == TGT_INTERNAL && reset_pc == BOOT_PC)); // R1
  AST_STD_TO_APP: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_ready && reset_pc == '0) |->
      (dispatch_tgt == TGT_USER_APP && flash_marker == MARK_STD)); // R3
  AST_IDLE_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_ready |-> (reset_pc == '0 && !boot_map_en && flash_marker == MARK_STD)); // R4
  AST_USER_BOOT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch_tgt == TGT_USER_BOOT) |->
      (dispatch_addr[PAGE_W-1:0] == '0 && dispatch_addr[ADDR_W-1:PAGE_W] < BOOT_PAGE[VEC_W-1:0])); // R5
  AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    boot_ready |=> ($stable(reset_pc) && $stable(flash_marker) &&
                    $stable(dispatch_tgt) && $stable(dispatch_addr) && boot_ready)); // R8
endmodule

// File: tb/boot_source_sel_tb.sv
module boot_source_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_N     = 2;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        isp_force_n = 1'b1;
  logic        fuse_jump_n = 1'b1;
  logic [7:0]  sw_boot_vec = 8'hFF;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_wr_data = 8'h00;
  logic [7:0]  reg_rd_data;
  logic        boot_map_en;
  logic        boot_ready;
  logic [15:0] reset_pc;
  logic [7:0]  flash_marker;
  logic [1:0]  dispatch_tgt;
  logic [15:0] dispatch_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_source_sel dut_i (
    .clk(clk), .rst_n(rst_n), .isp_force_n(isp_force_n), .fuse_jump_n(fuse_jump_n),
    .sw_boot_vec(sw_boot_vec), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .boot_map_en(boot_map_en), .boot_ready(boot_ready),
    .reset_pc(reset_pc), .flash_marker(flash_marker), .dispatch_tgt(dispatch_tgt),
    .dispatch_addr(dispatch_addr)
  );

  // Behavioural reference model
  bit        pin_hist[$];
  int        m_edges;
  bit        m_ready;
  bit        m_en;
  int        m_pc;
  int        m_marker;
  int        m_vec;
  int        m_aux;
  string     m_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hist.delete();
      for (int i = 0; i < SYNC_N; i++) pin_hist.push_back(1'b1);
      m_edges = 0; m_ready = 0; m_en = 0; m_pc = 0; m_marker = 8'hF0;
      m_vec = 8'hFF; m_aux = 0; m_tag = "R4";
    end else if (!m_ready) begin
      bit seen;
      seen = pin_hist.pop_front();
      pin_hist.push_back(isp_force_n);
      if (m_edges == SYNC_N) begin
        m_ready = 1;
        m_vec   = sw_boot_vec;
        if (!seen) begin
          m_en = 1; m_pc = 16'hF000; m_marker = 8'h00; m_tag = "R1";
        end else if (!fuse_jump_n) begin
          m_en = 1; m_pc = 16'hF000; m_marker = 8'hF0; m_tag = "R2";
        end else begin
          m_en = 0; m_pc = 0; m_marker = 8'hF0; m_tag = "R3";
        end
        m_aux = m_en ? 8'h20 : 8'h00;
      end else begin
        m_edges++;
      end
    end else if (reg_wr_en) begin
      m_aux = reg_wr_data & 8'h29;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int etgt, eaddr;
      string dtag;
      if (!m_en) begin etgt = 0; eaddr = 0; dtag = (m_ready ? "R3" : "R4"); end
      else if (m_marker == 8'h00) begin etgt = 2; eaddr = 16'hF000; dtag = "R1"; end
      else if (m_vec < 8'hF0) begin etgt = 1; eaddr = m_vec << 8; dtag = "R5"; end
      else begin etgt = 2; eaddr = 16'hF000; dtag = "R5"; end
      check("R4", "boot_ready", int'(boot_ready), int'(m_ready));
      check(m_tag, "reset_pc", int'(reset_pc), m_pc);
      check(m_tag, "flash_marker", int'(flash_marker), m_marker);
      check("R6", "boot_map_en", int'(boot_map_en), (m_aux >> 5) & 1);
      check(m_ready ? "R6" : "R7", "reg_rd_data", int'(reg_rd_data), m_aux);
      check(m_ready ? "R8" : dtag, "dispatch_tgt", int'(dispatch_tgt), etgt);
      check(dtag, "dispatch_addr", int'(dispatch_addr), eaddr);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic reg_write(logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_data = d;
    step(1);
    reg_wr_en = 1'b0;
  endtask

  // Reset with given inputs, optional early write and pin glitch, then post-ready changes
  task automatic run_case(bit pin, bit fuse, logic [7:0] vec, bit flip_pin);
    step(1);
    rst_n = 1'b0;
    isp_force_n = pin; fuse_jump_n = fuse; sw_boot_vec = vec;
    step(2);
    rst_n = 1'b1;               // R4: decision on third edge from here
    step(1);
    if (flip_pin) isp_force_n = ~pin;
    reg_write(8'hFF);           // R7: ignored, not ready yet
    step(3);
    // R8: inputs change after ready, decision must hold
    isp_force_n = ~isp_force_n; fuse_jump_n = ~fuse; sw_boot_vec = ~vec;
    step(2);
    // R6: register writes including reserved bits
    reg_write(8'hFF);
    reg_write(8'h04);
    reg_write(8'h09);
    reg_write(8'h20);
    reg_write(8'h00);           // R8: bit 5 cleared, dispatch unchanged
    step(2);
  endtask

  initial begin
    step(3);
    run_case(1'b0, 1'b1, 8'h12, 1'b0);  // R1
    run_case(1'b0, 1'b0, 8'h10, 1'b0);  // R1 over fuse
    run_case(1'b1, 1'b0, 8'h30, 1'b0);  // R2 + R5 user bootloader
    run_case(1'b1, 1'b0, 8'hEF, 1'b0);  // R5 just below limit
    run_case(1'b1, 1'b0, 8'hF0, 1'b0);  // R5 at limit -> internal
    run_case(1'b1, 1'b0, 8'hFF, 1'b0);  // R5 top
    run_case(1'b1, 1'b1, 8'h05, 1'b0);  // R3
    run_case(1'b0, 1'b1, 8'h40, 1'b1);  // R4 pin flips inside synchronizer
    run_case(1'b1, 1'b1, 8'h00, 1'b1);  // R4 flip the other way
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule